// File: doc/BRIEF.md
# Virtual-Machine ALU Execution Unit

This unit carries out the arithmetic and logic step of a register machine with 64-bit registers. A decoder outside the unit supplies a 4-bit operation code and a class bit that selects 32-bit or 64-bit operation. It also supplies a 16-bit offset field, the current value of the destination register, and a second operand. That operand is either a source register or a 32-bit immediate. The unit returns the value to write back to the destination register.

A one-cycle `start` pulse launches an operation, and a one-cycle `done` pulse marks the result as valid. Most operations finish one cycle after `start`. Divide and remainder run on an iterative restoring divider that retires one quotient bit per cycle. It runs 32 steps in the 32-bit class and 64 steps in the 64-bit class. A zero divisor skips the iterations.

The offset field splits two operation codes. For the move code it chooses between a plain copy and a sign-extending copy. For the divide and remainder codes it chooses between unsigned and signed arithmetic. Division by zero and signed overflow both return defined values and never trap.

Top module: `vmalu_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `busy` and `done` are 0 after that edge and `result` is 0.
- R2: Any accepted operation other than divide (code 0x3) and remainder (code 0x9) raises `done` for exactly one cycle, one cycle after `start`.
- R3: Code 0x0 adds, 0x1 subtracts (dst minus operand), 0x4 ORs, 0x5 ANDs and 0xa XORs. Code 0xb with offset 0, or with any offset other than 8, 16 or 32, copies the operand.
- R4: Code 0x6 shifts dst left, 0x7 shifts it right logically, and 0xc shifts it right while filling with copies of the sign bit. The shift count is the operand ANDed with 63 in the 64-bit class and with 31 in the 32-bit class.
- R5: Code 0xb with offset 8, 16 or 32 copies the low 8, 16 or 32 operand bits and fills every higher bit with the top copied bit. In the 32-bit class the fill stops at bit 31, so offset 32 gives the low 32 operand bits.
- R6: With `use_imm` high, the operand is `imm_val`, sign extended to 64 bits in the 64-bit class and zero extended in the 32-bit class, and `src_val` has no effect. With `use_imm` low, the operand is `src_val`.
- R7: With `wide` low, only the low 32 bits of dst and of the operand take part, and result bits 63..32 are 0.
- R8: Code 0x3 gives the quotient of dst by the operand and code 0x9 gives the remainder. Offset 1 selects signed arithmetic and any other offset selects unsigned. Signed quotients truncate toward zero, and signed remainders take the sign of dst.
- R9: When the class-trimmed operand is zero, divide returns 0 and remainder returns the class-trimmed dst, with `done` two cycles after `start`.
- R10: A signed divide of the most negative class value by -1 returns that most negative value, and the matching signed remainder returns 0.
- R11: With a nonzero divisor, `done` comes 34 cycles after `start` in the 32-bit class and 66 cycles after `start` in the 64-bit class, and `busy` is high from the cycle after `start` until `done`.
- R12: A `start` pulse that arrives while `busy` is high is ignored: no extra `done` appears, and the running operation's result is delivered.
- R13: Codes 0x2, 0x8, 0xd, 0xe and 0xf return dst, trimmed to the class as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request; accepted only while `busy` is low |
| op_code | input | 4 | Operation code (upper nibble of the machine opcode) |
| wide | input | 1 | 1 selects the 64-bit class, 0 the 32-bit class |
| offset | input | 16 | Offset field: selects the sign-extension width or signed arithmetic |
| use_imm | input | 1 | 1 takes the operand from `imm_val`, 0 from `src_val` |
| dst_val | input | 64 | Current value of the destination register |
| src_val | input | 64 | Source register value |
| imm_val | input | 32 | Immediate value |
| busy | output | 1 | Divider is occupied |
| done | output | 1 | One-cycle pulse: `result` is valid |
| result | output | 64 | Value to write back to the destination |

## Verification
The assertions assume that `op_code`, `wide`, `offset`, `use_imm` and the operand buses are valid in any cycle where `start` is high. They also assume that the operand values matter only in that cycle, because the unit captures everything it needs on acceptance. The stimulus changes all inputs together on the falling edge, holds `start` for a single cycle and waits for `done` before issuing the next request. The one exception is a deliberate overlapping pulse used to exercise the busy-ignore rule. Sweeps over eight operand patterns cover sign bits at both class boundaries, zero, -1 and the extreme signed values, in both classes and with both operand sources.

// File: rtl/vmalu_pkg.sv
// Shared definitions for the VM ALU execution unit.
// Assumes the 4-bit operation code is the upper nibble of the machine opcode.
package vmalu_pkg;

    localparam int unsigned WORD_W = 64;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_DIV  = 4'h3,
        OP_OR   = 4'h4,
        OP_AND  = 4'h5,
        OP_LSH  = 4'h6,
        OP_RSH  = 4'h7,
        OP_MOD  = 4'h9,
        OP_XOR  = 4'ha,
        OP_MOV  = 4'hb,
        OP_ARSH = 4'hc
    } alu_op_e;

    localparam logic [15:0] OFF_SIGNED = 16'd1;
    localparam logic [15:0] OFF_SX8    = 16'd8;
    localparam logic [15:0] OFF_SX16   = 16'd16;
    localparam logic [15:0] OFF_SX32   = 16'd32;

    // True for the two codes served by the iterative divider.
    function automatic logic is_divmod(input logic [3:0] op);
        return (op == OP_DIV) || (op == OP_MOD);
    endfunction

endpackage

// File: rtl/vmalu_opsel.sv
// Operand selection: picks register or immediate as the second operand and
// trims both operands to the active class.
// Assumes the immediate is half the data width.
module vmalu_opsel #(
    parameter int unsigned W = 64
) (
    input  logic           wide,
    input  logic           use_imm,
    input  logic [W-1:0]   dst_in,
    input  logic [W-1:0]   src_in,
    input  logic [W/2-1:0] imm_in,
    output logic [W-1:0]   a_out,
    output logic [W-1:0]   b_out
);
    localparam int unsigned HW = W / 2;

    logic [W-1:0] imm_ext;
    logic [W-1:0] b_raw;

    // Widen the immediate: sign fill for the wide class, zero fill otherwise.
    always_comb begin
        imm_ext = wide ? {{HW{imm_in[HW-1]}}, imm_in} : {{HW{1'b0}}, imm_in};
    end

    // Choose the operand source.
    always_comb begin
        b_raw = use_imm ? imm_ext : src_in;
    end

    // Trim both operands to the class width.
    always_comb begin
        a_out = wide ? dst_in : {{HW{1'b0}}, dst_in[HW-1:0]};
        b_out = wide ? b_raw  : {{HW{1'b0}}, b_raw[HW-1:0]};
    end
endmodule

// File: rtl/vmalu_exec.sv
// Single-cycle datapath: add, subtract, logic, shifts, move and
// sign-extending move. Purely combinational.
// Assumes the operands are already trimmed to the class (upper half zero
// when wide is low).
module vmalu_exec #(
    parameter int unsigned W = 64
) (
    input  logic [3:0]   op,
    input  logic         wide,
    input  logic [15:0]  offset,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    import vmalu_pkg::*;

    localparam int unsigned HW   = W / 2;
    localparam int unsigned SH_W = $clog2(W);
    localparam int unsigned N_SX = 3;

    logic [SH_W-1:0] sh;
    logic [W-1:0]    shl_v, shr_v, sar_v;
    logic [HW-1:0]   a_lo;
    logic [HW-1:0]   shl_lo, shr_lo, sar_lo;
    logic [W-1:0]    sx_v [N_SX];
    logic [W-1:0]    mov_v;
    logic [W-1:0]    raw;

    // Shift count masked by the class: all count bits when wide, one fewer when narrow.
    always_comb begin
        sh = b[SH_W-1:0] & (wide ? {SH_W{1'b1}} : {1'b0, {(SH_W-1){1'b1}}});
    end

    // Full-width shifts.
    always_comb begin
        shl_v = a << sh;
        shr_v = a >> sh;
        sar_v = W'($signed(a) >>> sh);
    end

    // Half-width shifts for the narrow class.
    always_comb begin
        a_lo   = a[HW-1:0];
        shl_lo = a_lo << sh;
        shr_lo = a_lo >> sh;
        sar_lo = HW'($signed(a_lo) >>> sh);
    end

    // One sign-extension path per source width: 8, 16, 32 bits.
    for (genvar g = 0; g < N_SX; g++) begin : g_sx
        localparam int unsigned SW = 8 << g;
        always_comb begin
            sx_v[g] = {{(W-SW){b[SW-1]}}, b[SW-1:0]};
        end
    end

    // Move variant picked by the offset field.
    always_comb begin
        case (offset)
            OFF_SX8:  mov_v = sx_v[0];
            OFF_SX16: mov_v = sx_v[1];
            OFF_SX32: mov_v = sx_v[2];
            default:  mov_v = b;
        endcase
    end

    // Operation select.
    always_comb begin
        case (op)
            OP_ADD:  raw = a + b;
            OP_SUB:  raw = a - b;
            OP_OR:   raw = a | b;
            OP_AND:  raw = a & b;
            OP_XOR:  raw = a ^ b;
            OP_LSH:  raw = wide ? shl_v : {{HW{1'b0}}, shl_lo};
            OP_RSH:  raw = wide ? shr_v : {{HW{1'b0}}, shr_lo};
            OP_ARSH: raw = wide ? sar_v : {{HW{1'b0}}, sar_lo};
            OP_MOV:  raw = mov_v;
            default: raw = a;
        endcase
    end

    // Clear the upper half in the narrow class.
    always_comb begin
        res = wide ? raw : {{HW{1'b0}}, raw[HW-1:0]};
    end
endmodule

// File: rtl/vmalu_divider.sv
// Iterative restoring divider with signed fix-up, one quotient bit per cycle.
// The narrow class preloads the dividend into the upper half and runs half
// the steps. A zero divisor goes straight to the finish state.
// Assumes the operands are trimmed to the class; start is sampled only in IDLE.
module vmalu_divider #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         wide,
    input  logic         sgn,
    input  logic         want_rem,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         busy,
    output logic         fin,
    output logic [W-1:0] res
);
    localparam int unsigned HW = W / 2;
    localparam int unsigned CW = $clog2(W + 1);

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} dstate_e;

    dstate_e       state;
    logic [W-1:0]  q_r, rem_r, d_r, keep_r;
    logic [CW-1:0] cnt;
    logic          wide_r, neg_q_r, neg_r_r, rem_sel_r, dz_r;

    logic [W-1:0]  cls_mask, a_neg, b_neg, mag_a, mag_b;
    logic          neg_a, neg_b;
    logic [W:0]    rem_sh, rem_sub;
    logic          take;
    logic [W-1:0]  quo_v, rem_v, out_mask, pick;

    // Sign and magnitude of the operands at launch.
    always_comb begin
        cls_mask = wide ? {W{1'b1}} : {{HW{1'b0}}, {HW{1'b1}}};
        neg_a    = sgn && (wide ? a[W-1] : a[HW-1]);
        neg_b    = sgn && (wide ? b[W-1] : b[HW-1]);
        a_neg    = (~a + 1'b1) & cls_mask;
        b_neg    = (~b + 1'b1) & cls_mask;
        mag_a    = neg_a ? a_neg : a;
        mag_b    = neg_b ? b_neg : b;
    end

    // One restoring step: trial subtract, keep it when it does not borrow.
    always_comb begin
        rem_sh  = {rem_r, q_r[W-1]};
        rem_sub = rem_sh - {1'b0, d_r};
        take    = !rem_sub[W];
    end

    // Sequencing and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            q_r       <= '0;
            rem_r     <= '0;
            d_r       <= '0;
            keep_r    <= '0;
            cnt       <= '0;
            wide_r    <= 1'b0;
            neg_q_r   <= 1'b0;
            neg_r_r   <= 1'b0;
            rem_sel_r <= 1'b0;
            dz_r      <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        q_r       <= wide ? mag_a : (mag_a << HW);
                        rem_r     <= '0;
                        d_r       <= mag_b;
                        keep_r    <= a;
                        cnt       <= wide ? CW'(W) : CW'(HW);
                        wide_r    <= wide;
                        neg_q_r   <= neg_a ^ neg_b;
                        neg_r_r   <= neg_a;
                        rem_sel_r <= want_rem;
                        dz_r      <= (b == '0);
                        state     <= (b == '0) ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    rem_r <= take ? rem_sub[W-1:0] : rem_sh[W-1:0];
                    q_r   <= {q_r[W-2:0], take};
                    cnt   <= cnt - 1'b1;
                    if (cnt == CW'(1)) begin
                        state <= ST_FIN;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Sign fix-up and zero-divisor result in the finish state.
    always_comb begin
        quo_v    = neg_q_r ? (~q_r + 1'b1) : q_r;
        rem_v    = neg_r_r ? (~rem_r + 1'b1) : rem_r;
        out_mask = wide_r ? {W{1'b1}} : {{HW{1'b0}}, {HW{1'b1}}};
        if (dz_r) begin
            pick = rem_sel_r ? keep_r : '0;
        end else begin
            pick = rem_sel_r ? rem_v : quo_v;
        end
        res  = pick & out_mask;
        busy = (state != ST_IDLE);
        fin  = (state == ST_FIN);
    end

    // R11: the step counter stays within the configured depth while running.
    p_cnt_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (cnt != '0 && cnt <= CW'(W)));

    // R11: the finish state lasts exactly one cycle.
    p_fin_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> (state == ST_IDLE));

    // R9: a zero divisor skips the iterations.
    p_dz_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && b == '0) |=> fin);
endmodule

// File: rtl/vmalu_top.sv
// VM ALU execution unit top: operand selection, single-cycle datapath and
// iterative divider, with a registered result and a one-cycle done pulse.
// Assumes start is a pulse. A start that arrives while busy is ignored.
module vmalu_top #(
    parameter int unsigned DATA_W = vmalu_pkg::WORD_W,
    parameter int unsigned IMM_W  = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        op_code,
    input  logic              wide,
    input  logic [15:0]       offset,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm_val,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);
    import vmalu_pkg::*;

    localparam int unsigned HW = DATA_W / 2;

    logic [DATA_W-1:0] a_eff, b_eff, exec_res, div_res;
    logic              div_busy, div_fin, accept, is_dm, div_go;
    logic [DATA_W-1:0] result_q;
    logic              done_q, wide_q;

    vmalu_opsel #(.W(DATA_W)) u_opsel (
        .wide    (wide),
        .use_imm (use_imm),
        .dst_in  (dst_val),
        .src_in  (src_val),
        .imm_in  (imm_val),
        .a_out   (a_eff),
        .b_out   (b_eff)
    );

    vmalu_exec #(.W(DATA_W)) u_exec (
        .op     (op_code),
        .wide   (wide),
        .offset (offset),
        .a      (a_eff),
        .b      (b_eff),
        .res    (exec_res)
    );

    // Request acceptance and routing.
    always_comb begin
        accept = start && !div_busy;
        is_dm  = is_divmod(op_code);
        div_go = accept && is_dm;
    end

    vmalu_divider #(.W(DATA_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_go),
        .wide     (wide),
        .sgn      (offset == OFF_SIGNED),
        .want_rem (op_code == OP_MOD),
        .a        (a_eff),
        .b        (b_eff),
        .busy     (div_busy),
        .fin      (div_fin),
        .res      (div_res)
    );

    // Result register and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
            wide_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                wide_q <= wide;
            end
            if (accept && !is_dm) begin
                result_q <= exec_res;
                done_q   <= 1'b1;
            end else if (div_fin) begin
                result_q <= div_res;
                done_q   <= 1'b1;
            end
        end
    end

    assign busy   = div_busy;
    assign done   = done_q;
    assign result = result_q;

    // R2: done is a single-cycle pulse.
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: a non-divide request completes on the next cycle.
    p_single_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_dm) |=> done);

    // R7: narrow-class results carry a clear upper half.
    p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wide_q) |-> (result[DATA_W-1:HW] == '0));

    // R9: divide by zero completes two cycles after start.
    p_divzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (div_go && b_eff == '0) |=> ##1 done);

    // R11: no done while the divider is still iterating.
    p_no_early_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (div_busy && !div_fin) |=> !done);
endmodule

// File: tb/vmalu_top_test.sv
module vmalu_top_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [3:0]  op_code;
    logic        wide;
    logic [15:0] offset;
    logic        use_imm;
    logic [63:0] dst_val, src_val;
    logic [31:0] imm_val;
    logic        busy, done;
    logic [63:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit ended   = 0;

    always #2 clk = ~clk;

    vmalu_top uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
        .wide(wide), .offset(offset), .use_imm(use_imm), .dst_val(dst_val),
        .src_val(src_val), .imm_val(imm_val), .busy(busy), .done(done),
        .result(result)
    );

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            finish_run();
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(input int i);
        case (i)
            0: return 64'h0;
            1: return 64'h1;
            2: return 64'hFFFF_FFFF_FFFF_FFFF;
            3: return 64'h8000_0000_0000_0000;
            4: return 64'h0000_0000_8000_0000;
            5: return 64'h7FFF_FFFF_FFFF_FFFF;
            6: return 64'h1234_5678_9ABC_DE86;
            default: return 64'hFFFF_FFFF_FFFF_8005;
        endcase
    endfunction

    function automatic logic [63:0] opnd(input logic wd, input logic ui,
                                         input logic [63:0] s, input logic [31:0] im);
        logic [63:0] b;
        b = ui ? (wd ? {{32{im[31]}}, im} : {32'h0, im}) : s;
        if (!wd) b = {32'h0, b[31:0]};
        return b;
    endfunction

    function automatic logic [63:0] model(input logic [3:0] op, input logic wd,
            input logic [15:0] off, input logic ui, input logic [63:0] d,
            input logic [63:0] s, input logic [31:0] im);
        logic [63:0] a, b, r;
        logic [31:0] a32, b32, t32;
        longint sa, sb;
        int sa32, sb32;
        b   = opnd(wd, ui, s, im);
        a   = wd ? d : {32'h0, d[31:0]};
        a32 = a[31:0];
        b32 = b[31:0];
        case (op)
            4'h0: r = a + b;
            4'h1: r = a - b;
            4'h4: r = a | b;
            4'h5: r = a & b;
            4'ha: r = a ^ b;
            4'h6: r = wd ? (a << b[5:0]) : {32'h0, a32 << b32[4:0]};
            4'h7: r = wd ? (a >> b[5:0]) : {32'h0, a32 >> b32[4:0]};
            4'hc: begin
                t32 = $signed(a32) >>> b32[4:0];
                r = wd ? 64'($signed(a) >>> b[5:0]) : {32'h0, t32};
            end
            4'hb: case (off)
                16'd8:  r = {{56{b[7]}}, b[7:0]};
                16'd16: r = {{48{b[15]}}, b[15:0]};
                16'd32: r = {{32{b[31]}}, b[31:0]};
                default: r = b;
            endcase
            4'h3, 4'h9: begin
                if (b == 64'h0) r = (op == 4'h9) ? a : 64'h0;
                else if (off != 16'd1) r = (op == 4'h9) ? a % b : a / b;
                else if (wd) begin
                    sa = $signed(a); sb = $signed(b);
                    if (a == 64'h8000_0000_0000_0000 && b == 64'hFFFF_FFFF_FFFF_FFFF)
                        r = (op == 4'h9) ? 64'h0 : a;
                    else r = (op == 4'h9) ? 64'(sa % sb) : 64'(sa / sb);
                end else begin
                    sa32 = $signed(a32); sb32 = $signed(b32);
                    if (a32 == 32'h8000_0000 && b32 == 32'hFFFF_FFFF)
                        r = (op == 4'h9) ? 64'h0 : {32'h0, a32};
                    else r = {32'h0, 32'((op == 4'h9) ? (sa32 % sb32) : (sa32 / sb32))};
                end
            end
            default: r = a;
        endcase
        if (!wd) r = {32'h0, r[31:0]};
        return r;
    endfunction

    function automatic int exp_lat(input logic [3:0] op, input logic wd, input logic [63:0] b);
        if (op != 4'h3 && op != 4'h9) return 1;
        if (b == 64'h0) return 2;
        return wd ? 66 : 34;
    endfunction

    function automatic string req_of(input logic [3:0] op, input logic [15:0] off);
        case (op)
            4'h0, 4'h1, 4'h4, 4'h5, 4'ha: return "R3";
            4'h6, 4'h7, 4'hc: return "R4";
            4'hb: return (off == 16'd8 || off == 16'd16 || off == 16'd32) ? "R5" : "R3";
            4'h3, 4'h9: return "R8";
            default: return "R13";
        endcase
    endfunction

    task automatic run_op(input logic [3:0] op, input logic wd, input logic [15:0] off,
                          input logic ui, input logic [63:0] d, input logic [63:0] s,
                          input logic [31:0] im, input string tag);
        int lat;
        logic [63:0] b;
        @(negedge clk);
        op_code = op; wide = wd; offset = off; use_imm = ui;
        dst_val = d; src_val = s; imm_val = im; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        b = opnd(wd, ui, s, im);
        chk(tag, result, model(op, wd, off, ui, d, s, im));
        chk({tag, " latency R11"}, 64'(lat), 64'(exp_lat(op, wd, b)));
    endtask

    function automatic logic [19:0] sweep_op(input int k);
        case (k)
            0:  return {4'h0, 16'd0};
            1:  return {4'h1, 16'd0};
            2:  return {4'h4, 16'd0};
            3:  return {4'h5, 16'd0};
            4:  return {4'ha, 16'd0};
            5:  return {4'h6, 16'd0};
            6:  return {4'h7, 16'd0};
            7:  return {4'hc, 16'd0};
            8:  return {4'hb, 16'd0};
            9:  return {4'hb, 16'd8};
            10: return {4'hb, 16'd16};
            11: return {4'hb, 16'd32};
            12: return {4'hb, 16'd5};
            13: return {4'h2, 16'd0};
            14: return {4'hd, 16'd0};
            15: return {4'h3, 16'd0};
            16: return {4'h3, 16'd1};
            17: return {4'h9, 16'd0};
            default: return {4'h9, 16'd1};
        endcase
    endfunction

    initial begin
        int ndone;
        rst_n = 1'b0; start = 1'b0; op_code = 4'h0; wide = 1'b1; offset = 16'h0;
        use_imm = 1'b0; dst_val = 64'h0; src_val = 64'h0; imm_val = 32'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", 64'(busy), 64'h0);
        chk("R1 done", 64'(done), 64'h0);
        chk("R1 result", result, 64'h0);
        rst_n = 1'b1;

        // R5: 8-bit 0x86 sign extended
        run_op(4'hb, 1'b1, 16'd8, 1'b0, 64'h0, 64'h86, 32'h0, "R5 sx8");
        chk("R5 sx8 value", result, 64'hFFFF_FFFF_FFFF_FF86);
        // R2: single-cycle path
        run_op(4'h0, 1'b1, 16'd0, 1'b0, 64'd5, 64'd7, 32'h0, "R2 add");
        // R6: immediate sign extension in wide class, src ignored
        run_op(4'h0, 1'b1, 16'd0, 1'b1, 64'd10, 64'h5555, 32'hFFFF_FFFF, "R6 imm");
        chk("R6 imm value", result, 64'd9);
        // R9: divide and modulo by zero
        run_op(4'h3, 1'b1, 16'd1, 1'b0, 64'd77, 64'd0, 32'h0, "R9 sdiv0");
        run_op(4'h9, 1'b0, 16'd0, 1'b0, 64'hABCD_0000_0000_0042, 64'hFFFF_FFFF_0000_0000, 32'h0, "R9 mod0 narrow");
        chk("R9 mod0 value", result, 64'h42);
        // R10: signed overflow
        run_op(4'h3, 1'b1, 16'd1, 1'b0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0, "R10 sdiv");
        run_op(4'h9, 1'b1, 16'd1, 1'b0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0, "R10 smod");
        run_op(4'h3, 1'b0, 16'd1, 1'b1, 64'h8000_0000, 64'h0, 32'hFFFF_FFFF, "R10 sdiv narrow");
        chk("R10 sdiv narrow value", result, 64'h8000_0000);
        // R8: signed truncation toward zero, remainder sign of dividend
        run_op(4'h9, 1'b1, 16'd1, 1'b0, -64'sd7, 64'd2, 32'h0, "R8 smod");
        chk("R8 smod value", result, -64'sd1);

        // R12: start during busy is ignored
        @(negedge clk);
        op_code = 4'h3; wide = 1'b1; offset = 16'd0; use_imm = 1'b0;
        dst_val = 64'd1000; src_val = 64'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        op_code = 4'h0; dst_val = 64'd1; src_val = 64'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ndone = 0;
        for (int i = 0; i < 70; i++) begin
            if (done) begin
                ndone++;
                chk("R12 result", result, 64'd142);
            end
            @(negedge clk);
        end
        chk("R12 done count", 64'(ndone), 64'd1);
        chk("R11 busy idle after", 64'(busy), 64'd0);

        // Sweeps: R3 R4 R5 R8 R13, both classes (R7), both sources (R6)
        for (int k = 0; k < 19; k++) begin
            for (int wd = 0; wd < 2; wd++) begin
                for (int ui = 0; ui < 2; ui++) begin
                    for (int i = 0; i < 8; i++) begin
                        for (int j = 0; j < 8; j++) begin
                            logic [19:0] so;
                            string tg;
                            so = sweep_op(k);
                            tg = $sformatf("%s%s%s op%h off%0d d%0d s%0d", req_of(so[19:16], so[15:0]),
                                           wd ? "" : "/R7", ui ? "/R6" : "", so[19:16], so[15:0], i, j);
                            run_op(so[19:16], 1'(wd), so[15:0], 1'(ui), pat(i),
                                   ui ? ~pat(j) : pat(j), pat(j) >> 0, tg);
                        end
                    end
                end
            end
        end
        finish_run();
    end
endmodule